// File: doc/BRIEF.md
# Match Timer with Event Counting

This block is a counter that raises a sticky interrupt flag when its count reaches a programmed match value. It has two count sources. In timer mode it advances on ticks of a power-of-two prescaler driven by the system clock. In event mode it advances on qualified edges of an asynchronous external input. The edges counted can be rising only, falling only, or both.

A level start/stop control governs a run. While the control is low, the counter stays at zero. In single-shot mode, a run ends at the match and the counter holds the match value. In repeating mode, the counter shows the match value for one cycle and then restarts from zero.

The interrupt flag is gated by an enable and stays set until it is cleared.

Top module: `match_timer`

## Requirements
- R1: After reset, `count_o` is 0 and `irq_o` is 0.
- R2: With `src_i`=0 and `run_i`=1, the counter advances once every 2^`presc_sel_i` clock cycles. The first advance falls on the 2^`presc_sel_i`-th rising edge with `run_i` high.
- R3: When an advance makes the count equal a nonzero `match_i` and `irq_en_i` is high, `irq_o` rises on the same clock edge that `count_o` takes the match value.
- R4: With `repeat_i`=0, after a match the counter holds the match value and ignores further ticks until `run_i` goes low.
- R5: With `repeat_i`=1, the count holds the match value for exactly one cycle, becomes 0 on the next edge, and then counts on.
- R6: While `run_i` is low, `count_o` is 0 on the following edge and a finished single-shot run is re-armed.
- R7: With `src_i`=1 and `edge_sel_i`=2'b00, each 0-to-1 transition of `evt_i` advances the count once. The advance happens on the third rising clock edge that samples the new level.
- R8: With `edge_sel_i`=2'b01, only 1-to-0 transitions of `evt_i` advance the count, with the same latency as R7.
- R9: With `edge_sel_i`=2'b10 or 2'b11, both transitions of `evt_i` advance the count, with the same latency as R7.
- R10: `irq_o` stays set until `irq_clr_i` is sampled high. It then clears on that edge unless R11 applies.
- R11: A clear and a new enabled match on the same edge leave `irq_o` set.
- R12: With `irq_en_i` low, a match does not set `irq_o`, and counting behaves as in R4 and R5.
- R13: With `match_i`=0, no match occurs and no interrupt is raised. The counter counts freely and wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| presc_sel_i | input | PSEL_W | Prescaler exponent: timer divides by 2^value |
| src_i | input | 1 | Count source: 0 prescaled clock, 1 external events |
| edge_sel_i | input | 2 | 00 rising, 01 falling, 10/11 both edges |
| match_i | input | CNT_W | Match value; 0 disables matching |
| repeat_i | input | 1 | 0 single-shot, 1 repeating |
| run_i | input | 1 | Start (high) / stop and clear (low) |
| evt_i | input | 1 | Asynchronous external event input |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Clear for the interrupt flag |
| irq_o | output | 1 | Sticky interrupt flag |
| count_o | output | CNT_W | Current count |

## Verification
The hardest case to reach is a clear that lands on the same edge as a new match. It needs a flag that is already set and a clear timed to a specific cycle. The bench reaches it in repeating mode with an undivided clock. It lets the first match set the flag, then watches the count. When the count is one below the match value it raises the clear, so the clear coincides with the next match edge.

Event-mode latency through the synchronizer is exercised with each of the three edge selections. A behavioural model runs every clock and is compared against the outputs throughout.

// File: rtl/match_timer_pkg.sv
// Shared encodings for the match timer.
package match_timer_pkg;
    // Edge qualification selection for event counting.
    typedef enum logic [1:0] {
        EDGE_RISE  = 2'b00,
        EDGE_FALL  = 2'b01,
        EDGE_BOTH  = 2'b10,
        EDGE_BOTH2 = 2'b11
    } edge_sel_e;
endpackage

// File: rtl/mt_prescaler.sv
// Power-of-two prescaler: emits a one-cycle tick every 2^sel_i cycles while
// run_i is high. Assumes sel_i is held stable during a run.
module mt_prescaler #(
    parameter int PSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [PSEL_W-1:0] sel_i,
    output logic              tick_o
);
    localparam int DIV_W = (2 ** PSEL_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W:0]   mask_full;
    logic [DIV_W-1:0] mask;

    // Free-running divider, cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Tick when all bits below the selected exponent are ones.
    always_comb begin
        mask_full = ({{DIV_W{1'b0}}, 1'b1} << sel_i) - 1'b1;
        mask      = mask_full[DIV_W-1:0];
        tick_o    = ((div_q & mask) == mask);
    end
endmodule

// File: rtl/mt_edge_qual.sv
// Synchronizes an asynchronous event input and emits one pulse per qualified
// edge. Assumes the input stays at each level for several clock cycles.
module mt_edge_qual
    import match_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_i,
    input  logic [1:0] edge_sel_i,
    output logic       pulse_o
);
    logic sync1_q, sync2_q, prev_q;
    logic rise, fall;

    // Two-stage synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= evt_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    // Edge qualification by the selected mode.
    always_comb begin
        rise = sync2_q & ~prev_q;
        fall = ~sync2_q & prev_q;
        unique case (edge_sel_e'(edge_sel_i))
            EDGE_RISE: pulse_o = rise;
            EDGE_FALL: pulse_o = fall;
            default:   pulse_o = rise | fall;
        endcase
    end
endmodule

// File: rtl/mt_counter.sv
// Match counter: advances on inc_i, detects a nonzero match, holds (single
// shot) or reloads to zero one cycle later (repeating). Cleared while stopped.
module mt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             repeat_i,
    input  logic             inc_i,
    input  logic [CNT_W-1:0] match_i,
    output logic [CNT_W-1:0] count_o,
    output logic             hit_o,
    output logic             done_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic             done_q, wrap_q;
    logic             advance;

    // Match detection on the value the counter is about to take.
    always_comb begin
        cnt_nxt = cnt_q + 1'b1;
        advance = run_i && !done_q && !wrap_q && inc_i;
        hit_o   = advance && (match_i != '0) && (cnt_nxt == match_i);
    end

    // Count, hold and reload sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
            wrap_q <= 1'b0;
        end else if (wrap_q) begin
            cnt_q  <= '0;
            wrap_q <= 1'b0;
        end else if (advance) begin
            cnt_q <= cnt_nxt;
            if (hit_o) begin
                done_q <= !repeat_i;
                wrap_q <= repeat_i;
            end
        end
    end

    assign count_o = cnt_q;
    assign done_o  = done_q;
    assign wrap_o  = wrap_q;
endmodule

// File: rtl/match_timer.sv
// Match timer top: selects prescaled clock ticks or qualified external edges
// as the count source and keeps a sticky, enable-gated interrupt flag.
// Assumes configuration inputs are stable while run_i is high.
module match_timer
    import match_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PSEL_W-1:0] presc_sel_i,
    input  logic              src_i,
    input  logic [1:0]        edge_sel_i,
    input  logic [CNT_W-1:0]  match_i,
    input  logic              repeat_i,
    input  logic              run_i,
    input  logic              evt_i,
    input  logic              irq_en_i,
    input  logic              irq_clr_i,
    output logic              irq_o,
    output logic [CNT_W-1:0]  count_o
);
    logic tick, evt_pulse, inc, hit, done_s, wrap_s;
    logic irq_q;

    mt_prescaler #(.PSEL_W(PSEL_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .sel_i(presc_sel_i), .tick_o(tick)
    );

    mt_edge_qual u_edge (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .edge_sel_i(edge_sel_i), .pulse_o(evt_pulse)
    );

    // Count source selection.
    assign inc = src_i ? evt_pulse : tick;

    mt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .repeat_i(repeat_i), .inc_i(inc),
        .match_i(match_i), .count_o(count_o), .hit_o(hit), .done_o(done_s), .wrap_o(wrap_s)
    );

    // Sticky interrupt flag; a new enabled match wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= (irq_q && !irq_clr_i) || (hit && irq_en_i);
        end
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/match_timer_checker.sv
// Temporal checks for match_timer, attached with bind.
module match_timer_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_i,
    input logic             irq_en_i,
    input logic             irq_clr_i,
    input logic             irq_o,
    input logic [CNT_W-1:0] match_i,
    input logic [CNT_W-1:0] count_o,
    input logic             done_s,
    input logic             wrap_s
);
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (count_o == '0)); // R6
    AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_s && run_i) |=> (count_o == $past(count_o))); // R4
    AST_REPEAT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_s |=> (count_o == '0)); // R5
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr_i) |=> irq_o); // R10
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(irq_en_i)); // R12
    AST_ZERO_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(match_i) != '0)); // R13
    AST_IRQ_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (count_o == $past(match_i))); // R3
endmodule

bind match_timer match_timer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .irq_en_i(irq_en_i),
    .irq_clr_i(irq_clr_i), .irq_o(irq_o), .match_i(match_i),
    .count_o(count_o), .done_s(done_s), .wrap_s(wrap_s)
);

// File: tb/match_timer_test.sv
module match_timer_test;
    localparam int CNT_W  = 16;
    localparam int PSEL_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PSEL_W-1:0] presc_sel_i = '0;
    logic              src_i = 1'b0;
    logic [1:0]        edge_sel_i = 2'b00;
    logic [CNT_W-1:0]  match_i = '0;
    logic              repeat_i = 1'b0;
    logic              run_i = 1'b0;
    logic              evt_i = 1'b0;
    logic              irq_en_i = 1'b0;
    logic              irq_clr_i = 1'b0;
    logic              irq_o;
    logic [CNT_W-1:0]  count_o;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";

    match_timer #(.CNT_W(CNT_W), .PSEL_W(PSEL_W)) uut (.*);

    always #5 clk = ~clk;

    // Behavioural reference model state.
    int m_cnt, m_pc;
    bit m_done, m_wrap, m_irq;
    bit evt_hist[$];

    always @(posedge clk) begin
        bit tk, hit, a, b, evq;
        int nx;
        if (!rst_n) begin
            m_cnt = 0; m_pc = 0; m_done = 0; m_wrap = 0; m_irq = 0;
            evt_hist = '{0, 0, 0};
        end else begin
            a = evt_hist[1];  // level seen two edges ago
            b = evt_hist[2];  // level seen three edges ago
            case (edge_sel_i)
                2'b00:   evq = a && !b;
                2'b01:   evq = !a && b;
                default: evq = a != b;
            endcase
            tk  = src_i ? evq : ((m_pc % (1 << presc_sel_i)) == (1 << presc_sel_i) - 1);
            hit = 0;
            if (!run_i) begin
                m_cnt = 0; m_done = 0; m_wrap = 0;
            end else if (m_wrap) begin
                m_cnt = 0; m_wrap = 0;
            end else if (!m_done && tk) begin
                nx = (m_cnt + 1) % (1 << CNT_W);
                hit = (match_i != 0) && (nx == match_i);
                m_cnt = nx;
                if (hit) begin
                    if (repeat_i) m_wrap = 1; else m_done = 1;
                end
            end
            m_pc = run_i ? (m_pc + 1) % (1 << 15) : 0;
            m_irq = (m_irq && !irq_clr_i) || (hit && irq_en_i);
            evt_hist.push_front(evt_i);
            void'(evt_hist.pop_back());
        end
    end

    task automatic check(string req, int act, int exp, string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, count_o, m_cnt, "count");
            check(cur_req, irq_o, m_irq, "irq");
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic stop_clear();
        run_i = 0; irq_clr_i = 1; cyc(1);
        irq_clr_i = 0; cyc(1);
    endtask

    task automatic toggle_evt(int n, int half);
        for (int i = 0; i < n; i++) begin
            evt_i = ~evt_i; cyc(half);
        end
    endtask

    initial begin : watchdog
        #1500000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        cur_req = "R1";
        check("R1", count_o, 0, "reset count");
        check("R1", irq_o, 0, "reset irq");

        // R2 R3 R4: undivided timer, single shot
        cur_req = "R4"; match_i = 5; irq_en_i = 1; run_i = 1;
        cyc(12);
        check("R4", count_o, 5, "single-shot hold");
        check("R3", irq_o, 1, "match irq");
        cur_req = "R10"; cyc(4);
        check("R10", irq_o, 1, "sticky");
        irq_clr_i = 1; cyc(1); irq_clr_i = 0;
        check("R10", irq_o, 0, "cleared");
        cur_req = "R6"; run_i = 0; cyc(1);
        check("R6", count_o, 0, "stop clears");
        run_i = 1; cyc(3);
        check("R6", count_o, 3, "re-armed run");
        stop_clear();

        // R2 R5: divide by 4, repeating
        cur_req = "R5"; presc_sel_i = 2; match_i = 3; repeat_i = 1; run_i = 1;
        cyc(4);
        check("R2", count_o, 1, "prescaled first tick");
        cyc(40);
        stop_clear();
        presc_sel_i = 0; repeat_i = 0;

        // R7 R8 R9: event counting
        src_i = 1; match_i = 3;
        cur_req = "R7"; edge_sel_i = 2'b00; run_i = 1;
        toggle_evt(10, 4); cyc(4);
        check("R7", count_o, 3, "rising events");
        stop_clear(); evt_i = 0; cyc(4);
        cur_req = "R8"; edge_sel_i = 2'b01; run_i = 1;
        toggle_evt(4, 4); cyc(4);
        check("R8", count_o, 2, "falling events");
        stop_clear(); evt_i = 0; cyc(4);
        cur_req = "R9"; edge_sel_i = 2'b10; match_i = 6; run_i = 1;
        toggle_evt(5, 5); cyc(4);
        check("R9", count_o, 5, "both edges");
        stop_clear(); evt_i = 0; src_i = 0;

        // R12: interrupt disabled
        cur_req = "R12"; irq_en_i = 0; match_i = 4; run_i = 1;
        cyc(10);
        check("R12", irq_o, 0, "disabled irq");
        check("R12", count_o, 4, "count still holds");
        stop_clear();

        // R11: clear coinciding with a new match
        cur_req = "R11"; irq_en_i = 1; repeat_i = 1; match_i = 4; run_i = 1;
        cyc(6);
        while (count_o != 3) cyc(1);
        irq_clr_i = 1; cyc(1); irq_clr_i = 0;
        check("R11", irq_o, 1, "clear vs match");
        cyc(1);
        check("R11", count_o, 0, "reload after match");
        stop_clear(); repeat_i = 0;

        // R13: zero match value
        cur_req = "R13"; match_i = 0; run_i = 1;
        cyc(300);
        check("R13", irq_o, 0, "no irq on zero match");
        check("R13", count_o, 300, "free count");
        stop_clear();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule